// File: doc/BRIEF.md
# Reset Control Register Port

This block is a one-byte register reached through an I/O port. Software uses it to do two things. It can choose which kind of system reset should happen, and it can ask for that reset. The block gets single-byte accesses: an address, a write enable with write data, and a read enable. It drives the read data back in the same cycle.

Each write to the port is handled in one of two ways, depending on bit 2 of the data. If bit 2 is set, the write is a trigger. It sends out a one-cycle reset-request pulse and leaves the stored byte alone. If bit 2 is clear, the write stores bit 1, the reset-type select, and clears every other bit of the stored byte. The stored type bit is also driven on its own output, so the logic that carries out the reset can see which type was chosen. That reset logic is outside this block.

Top module: `rst_ctl_port`

## Requirements
- R1: While the asynchronous active-low reset is asserted, the stored byte is 0x00 and the request output is low. After reset is released, a read returns 0x00 and the type output is low.
- R2: A write to the matching address with data bit 2 = 0 stores data bit 1 as the type bit. From the next cycle the type output equals that bit and every other stored bit is zero.
- R3: A write to the matching address with data bit 2 = 1 drives the request output high for exactly the one cycle after the write edge. Consecutive trigger writes give one pulse per write.
- R4: A trigger write (data bit 2 = 1) leaves the stored type bit unchanged, whatever the value of data bit 1.
- R5: A read from the matching address returns the stored byte, which is the type bit in position 1 with bits 7..2 and bit 0 always zero.
- R6: A write to any other address changes nothing. It produces no request pulse and leaves the type bit unchanged.
- R7: The read data is 0x00 whenever the read enable is low or the address does not match.
- R8: When a read and a write to the matching address fall in the same cycle, the read returns the byte that was stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accAddr | input | ADDR_W | Port address of the current access |
| accWrEn | input | 1 | Write strobe for one byte |
| accWrData | input | 8 | Write data |
| accRdEn | input | 1 | Read strobe for one byte |
| accRdData | output | 8 | Read data (combinational) |
| rstReq | output | 1 | One-cycle reset request pulse |
| rstType | output | 1 | Stored reset-type select |

## Verification
Two functions can meet in the same cycle. A read of the port can coincide with a write that changes the type bit, and a trigger write can land on the edge that follows another trigger write. The bench drives a matching read together with a storing write and expects the old byte back, then checks the new byte on the next read. It also issues two trigger writes back to back and expects the request high in both of the following cycles.

// File: rtl/rst_ctl_pkg.sv
package rst_ctl_pkg;
  localparam int DATA_W   = 8;
  localparam int TRIG_BIT = 2;
  localparam int TYPE_BIT = 1;

  typedef struct packed {
    logic storeType;
    logic fireReq;
    logic readHit;
  } ctlStrobes_t;
endpackage

// File: rtl/rst_ctl_decode.sv
module rst_ctl_decode
  import rst_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00F9
) (
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrEn,
  input  logic              accRdEn,
  input  logic [DATA_W-1:0] accWrData,
  output ctlStrobes_t       strobes
);
  logic addrHit;
  logic wrHit;

  assign addrHit = (accAddr == PORT_ADDR);
  assign wrHit   = accWrEn && addrHit;

  always_comb begin
    strobes.fireReq   = wrHit && accWrData[TRIG_BIT];
    strobes.storeType = wrHit && !accWrData[TRIG_BIT];
    strobes.readHit   = accRdEn && addrHit;
  end
endmodule

// File: rtl/rst_ctl_datapath.sv
module rst_ctl_datapath
  import rst_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              wrTypeBit,
  output logic [DATA_W-1:0] rdData,
  output logic              reqPulse,
  output logic              typeQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeQ    <= 1'b0;
      reqPulse <= 1'b0;
    end else begin
      reqPulse <= strobes.fireReq;
      if (strobes.storeType) typeQ <= wrTypeBit;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.readHit) rdData[TYPE_BIT] = typeQ;
  end

  // R3: a trigger strobe is followed by the request pulse
  p_req_after_trigger_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fireReq |=> reqPulse);
  // R3: no pulse without a trigger in the cycle before
  p_req_needs_trigger_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fireReq |=> !reqPulse);
  // R4: a trigger keeps the type bit
  p_type_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fireReq |=> $stable(typeQ));
  // R2: a storing write lands the written bit
  p_type_stored_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeType |=> (typeQ == $past(wrTypeBit)));
endmodule

// File: rtl/rst_ctl_port.sv
module rst_ctl_port
  import rst_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00F9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrEn,
  input  logic [7:0]        accWrData,
  input  logic              accRdEn,
  output logic [7:0]        accRdData,
  output logic              rstReq,
  output logic              rstType
);
  ctlStrobes_t strobes;

  rst_ctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) i_decode (
    .accAddr   (accAddr),
    .accWrEn   (accWrEn),
    .accRdEn   (accRdEn),
    .accWrData (accWrData),
    .strobes   (strobes)
  );

  rst_ctl_datapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrTypeBit (accWrData[TYPE_BIT]),
    .rdData    (accRdData),
    .reqPulse  (rstReq),
    .typeQ     (rstType)
  );

  // R6: a write elsewhere leaves the type and raises no request
  p_miss_no_effect_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accWrEn && accAddr != PORT_ADDR) |=> ($stable(rstType) && !rstReq));
  // R7: idle or missed read drives zero
  p_rd_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!accRdEn || accAddr != PORT_ADDR) |-> (accRdData == 8'h00));
  // R5: only the type position can read as one
  p_rd_fixed_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accRdData[7:2] == 6'b0) && !accRdData[0]);
endmodule

// File: tb/test_rst_ctl_port.sv
`timescale 1ns/1ps
module test_rst_ctl_port;
  localparam logic [15:0] PORT = 16'h00F9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] accAddr = '0;
  logic accWrEn = 1'b0;
  logic [7:0] accWrData = '0;
  logic accRdEn = 1'b0;
  logic [7:0] accRdData;
  logic rstReq;
  logic rstType;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rst_ctl_port #(.ADDR_W(16), .PORT_ADDR(PORT)) i_rst_ctl_port (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .accWrEn(accWrEn),
    .accWrData(accWrData), .accRdEn(accRdEn), .accRdData(accRdData),
    .rstReq(rstReq), .rstType(rstType)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // drive one write at a negedge; returns at the following negedge
  task automatic doWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    accAddr = a; accWrData = d; accWrEn = 1'b1;
    @(negedge clk);
    accWrEn = 1'b0; accWrData = '0;
  endtask

  task automatic readNow(logic [15:0] a, output logic [7:0] d);
    accAddr = a; accRdEn = 1'b1;
    #1 d = accRdData;
    accRdEn = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    logic expType;
    // R1: reset state
    #1;
    check("R1 req in reset", {7'b0, rstReq}, 8'h00);
    check("R1 type in reset", {7'b0, rstType}, 8'h00);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    readNow(PORT, rd);
    check("R1 read after reset", rd, 8'h00);
    check("R7 idle read zero", accRdData, 8'h00);

    // R2/R3/R4/R5: full data sweep, both prior type values
    for (int prior = 0; prior < 2; prior++) begin
      for (int v = 0; v < 256; v++) begin
        doWrite(PORT, 8'(prior << 1));
        expType = (v & 4) ? prior[0] : v[1];
        doWrite(PORT, 8'(v));
        check((v & 4) ? "R3 pulse on trigger" : "R3 no pulse on store",
              {7'b0, rstReq}, (v & 4) ? 8'h01 : 8'h00);
        check((v & 4) ? "R4 type kept" : "R2 type stored",
              {7'b0, rstType}, {7'b0, expType});
        readNow(PORT, rd);
        check("R5 read byte", rd, {6'b0, expType, 1'b0});
        @(negedge clk);
        check("R3 single cycle", {7'b0, rstReq}, 8'h00);
      end
    end

    // R6/R7: other addresses ignored
    doWrite(PORT, 8'h02);
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 8; d++) begin
        logic [15:0] other;
        other = PORT ^ 16'(1 << (a * 2));
        doWrite(other, 8'(d));
        check("R6 no pulse on miss", {7'b0, rstReq}, 8'h00);
        check("R6 type unchanged", {7'b0, rstType}, 8'h01);
        readNow(other, rd);
        check("R7 miss read zero", rd, 8'h00);
      end
    end

    // R8: read in the same cycle as a storing write
    @(negedge clk);
    accAddr = PORT; accWrData = 8'h00; accWrEn = 1'b1; accRdEn = 1'b1;
    #1 check("R8 read sees old byte", accRdData, 8'h02);
    @(negedge clk);
    accWrEn = 1'b0; accRdEn = 1'b0;
    readNow(PORT, rd);
    check("R8 new byte after write", rd, 8'h00);

    // R3: back-to-back triggers
    @(negedge clk);
    accAddr = PORT; accWrData = 8'h04; accWrEn = 1'b1;
    @(negedge clk);
    check("R3 first of pair", {7'b0, rstReq}, 8'h01);
    accWrData = 8'h06;
    @(negedge clk);
    accWrEn = 1'b0;
    check("R3 second of pair", {7'b0, rstReq}, 8'h01);
    check("R4 type after pair", {7'b0, rstType}, 8'h00);
    @(negedge clk);
    check("R3 pair ends", {7'b0, rstReq}, 8'h00);

    // R1: reset mid-run clears stored type
    doWrite(PORT, 8'h02);
    rstN = 1'b0;
    #1 check("R1 mid reset clears type", {7'b0, rstType}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    readNow(PORT, rd);
    check("R1 read after mid reset", rd, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule